// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer Bank

This block holds a bank of identical 32-bit interval timers that share one simple word-addressed register port (address, write enable, write data, registered read data). Each channel counts down once per clock while enabled. When it expires it records a pending event and drives its own interrupt line, unless that line is masked. A channel runs in one of two modes. In continuous mode it reloads itself and keeps counting. In single-shot mode it parks at zero until software restarts it.

Software programs a start value, picks the mode, and enables the channel. It can restart the count at any time through a reload strobe, or by enabling the channel again. The clear register also reports a short busy window after each expiry. Software polls that window before it acknowledges the event.

Top module: `tmr_bank`

## Requirements
- R1: After reset every channel is disabled, in single-shot mode, masked (mask bit reads 1), with count 0, nothing pending, busy clear, all interrupt lines low, and read data 0.
- R2: The count register returns the live counter value. While a channel is enabled the counter drops by one per clock. While it is disabled the counter holds its value.
- R3: Writing the enable register with bit 0 = 1 copies the start value into the counter and starts counting. Writing bit 0 = 0 stops the channel: the count held is the value after the decrement of that same edge.
- R4: Any write to the reload register copies the start value into the counter, whatever the data. Writing the start value alone leaves the counter unchanged.
- R5: In continuous mode (mode bit 0 = 1), an enabled counter that is at 0 is loaded with the start value on the next edge, and the pending flag is set on that edge. The expiry period is therefore start value + 1 cycles.
- R6: In single-shot mode (mode bit 0 = 0), an enabled counter that is at 0 sets the pending flag and then stays at 0, raising no further events, until a reload write or an enable write restarts it.
- R7: The clear register reads bit 0 = busy and bit 1 = pending. Busy is set for exactly the two cycles that follow each expiry edge.
- R8: Writing the clear register with bit 0 = 1 clears the pending flag only when busy is low. While busy is set the write is ignored. If an expiry happens on the same edge as an accepted clear, the expiry wins.
- R9: The mask register bit 0 = 1 masks the channel and 0 unmasks it. The interrupt line equals pending AND NOT mask, registered so that it changes on the same edge as pending or mask. A masked channel still records pending.
- R10: The address is {channel, register, 2'b00}, with the channel in bits [7:5] and a stride of 0x20. Register offsets are: 0x00 mode, 0x04 count (read only), 0x08 start value, 0x0C enable, 0x10 reload, 0x14 clear/status, 0x18 mask. Writes whose address bits [1:0] are not zero are ignored. Channels are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte address {channel, register, 2'b00} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address seen on the previous edge |
| irq_o | output | 8 | One interrupt line per channel |

## Verification
Several behaviours are checked by assertions on every cycle:
- that reload and enable writes copy the start value;
- that a continuous channel wraps from zero to the start value with pending set;
- that a parked single-shot channel stays at zero;
- that a disabled counter holds;
- that a clear is refused while busy;
- that busy accompanies every new pending event;
- that a masked line stays low;
- that at most one channel is addressed per write.

Other behaviours can only be shown by the bench's scenarios. These are the exact expiry cycle and period, the two-cycle length of the busy window, the restart value after a disable, and independence between channels at distinct addresses. The bench also checks that a misaligned write is dropped.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int REG_SEL_W = 3;

  typedef enum logic [REG_SEL_W-1:0] {
    RS_MODE   = 3'd0,
    RS_COUNT  = 3'd1,
    RS_LOAD   = 3'd2,
    RS_ENABLE = 3'd3,
    RS_RELOAD = 3'd4,
    RS_CLEAR  = 3'd5,
    RS_MASK   = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic mode_we;
    logic load_we;
    logic en_we;
    logic reload_we;
    logic clr_we;
    logic mask_we;
  } chan_wr_t;

  localparam int BUSY_CYCLES = 2;

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CH_W = $clog2(NCH),
  localparam int ADDR_W = CH_W + REG_SEL_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  output chan_wr_t [NCH-1:0]    wr_o
);

  logic [REG_SEL_W-1:0] rsel;
  logic                 aligned;
  logic [NCH-1:0]       hit;

  assign rsel    = addr[REG_SEL_W+1:2];
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign hit[i] = we && aligned && (addr[ADDR_W-1:REG_SEL_W+2] == CH_W'(i));
    always_comb begin
      wr_o[i]           = '0;
      wr_o[i].mode_we   = hit[i] && (rsel == RS_MODE);
      wr_o[i].load_we   = hit[i] && (rsel == RS_LOAD);
      wr_o[i].en_we     = hit[i] && (rsel == RS_ENABLE);
      wr_o[i].reload_we = hit[i] && (rsel == RS_RELOAD);
      wr_o[i].clr_we    = hit[i] && (rsel == RS_CLEAR);
      wr_o[i].mask_we   = hit[i] && (rsel == RS_MASK);
    end
  end

  AST_ONE_CHANNEL_HIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R10
  AST_MISALIGNED_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (addr[1:0] != 2'b00) |-> (hit == '0)); // R10

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  chan_wr_t         wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic             mode_o,
  output logic             en_o,
  output logic             mask_o,
  output logic             pend_o,
  output logic             busy_o,
  output logic             irq_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_d, load_q, load_d;
  logic              mode_q, mode_d, en_q, en_d, mask_q, mask_d;
  logic              pend_q, pend_d, halt_q, halt_d, irq_q, irq_d;
  logic [BUSY_W-1:0] busy_q, busy_d;
  logic              busy;
  logic              wbit;

  assign wbit = wdata[0];
  assign busy = (busy_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    load_d = wr.load_we ? wdata : load_q;
    mode_d = wr.mode_we ? wbit  : mode_q;
    mask_d = wr.mask_we ? wbit  : mask_q;
    en_d   = en_q;
    pend_d = pend_q;
    halt_d = halt_q;
    busy_d = busy ? busy_q - BUSY_W'(1) : '0;

    if (wr.clr_we && wbit && !busy) pend_d = 1'b0;

    if (en_q && !halt_q) begin
      if (cnt_q == '0) begin
        pend_d = 1'b1;
        busy_d = BUSY_W'(BUSY_CYCLES);
        if (mode_q) cnt_d = load_q;
        else        halt_d = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end

    if (wr.reload_we) begin
      cnt_d  = load_q;
      halt_d = 1'b0;
    end

    if (wr.en_we) begin
      en_d = wbit;
      if (wbit) begin
        cnt_d  = load_q;
        halt_d = 1'b0;
      end
    end

    irq_d = pend_d && !mask_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      mode_q <= 1'b0;
      en_q   <= 1'b0;
      mask_q <= 1'b1;
      pend_q <= 1'b0;
      halt_q <= 1'b0;
      busy_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      load_q <= load_d;
      mode_q <= mode_d;
      en_q   <= en_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      halt_q <= halt_d;
      busy_q <= busy_d;
      irq_q  <= irq_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign busy_o = busy;
  assign irq_o  = irq_q;

  AST_RELOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    wr.reload_we |=> (cnt_q == $past(load_q))); // R4
  AST_ENABLE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (wr.en_we && wbit) |=> (en_q && cnt_q == $past(load_q))); // R3
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !wr.reload_we && !wr.en_we) |=> $stable(cnt_q)); // R2
  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en_q && !halt_q && mode_q && cnt_q == '0 && !wr.reload_we && !wr.en_we)
      |=> (pend_q && cnt_q == $past(load_q))); // R5
  AST_SINGLE_PARKS: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !wr.reload_we && !wr.en_we) |=> (halt_q && cnt_q == '0)); // R6
  AST_BUSY_WITH_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> busy); // R7
  AST_CLEAR_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (wr.clr_we && busy && pend_q) |=> pend_q); // R8
  AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !irq_q); // R9

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 32,
  localparam int CH_W = $clog2(NCH),
  localparam int SEL_W = CH_W + REG_SEL_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [SEL_W-1:0]           sel,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_all,
  input  logic [NCH-1:0][CNT_W-1:0]  load_all,
  input  logic [NCH-1:0]             mode_all,
  input  logic [NCH-1:0]             en_all,
  input  logic [NCH-1:0]             mask_all,
  input  logic [NCH-1:0]             pend_all,
  input  logic [NCH-1:0]             busy_all,
  output logic [CNT_W-1:0]           rdata_o
);

  logic [CH_W-1:0]      ch;
  logic [REG_SEL_W-1:0] rs;
  logic [CNT_W-1:0]     rd_d;

  assign ch = sel[SEL_W-1:REG_SEL_W];
  assign rs = sel[REG_SEL_W-1:0];

  always_comb begin
    rd_d = '0;
    case (rs)
      RS_MODE:   rd_d[0] = mode_all[ch];
      RS_COUNT:  rd_d    = cnt_all[ch];
      RS_LOAD:   rd_d    = load_all[ch];
      RS_ENABLE: rd_d[0] = en_all[ch];
      RS_CLEAR:  rd_d[1:0] = {pend_all[ch], busy_all[ch]};
      RS_MASK:   rd_d[0] = mask_all[ch];
      default:   rd_d    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_d;
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CNT_W = 32,
  localparam int CH_W = $clog2(NCH),
  localparam int ADDR_W = CH_W + REG_SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq_o
);

  chan_wr_t [NCH-1:0]            wr;
  logic [NCH-1:0][CNT_W-1:0]     cnt_all, load_all;
  logic [NCH-1:0]                mode_all, en_all, mask_all, pend_all, busy_all;

  tmr_regdec #(.NCH(NCH)) u_dec (
    .clk  (clk),
    .rst  (rst),
    .we   (bus_we),
    .addr (bus_addr),
    .wr_o (wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .wr     (wr[i]),
      .wdata  (bus_wdata),
      .cnt_o  (cnt_all[i]),
      .load_o (load_all[i]),
      .mode_o (mode_all[i]),
      .en_o   (en_all[i]),
      .mask_o (mask_all[i]),
      .pend_o (pend_all[i]),
      .busy_o (busy_all[i]),
      .irq_o  (irq_o[i])
    );
  end

  tmr_rdmux #(.NCH(NCH), .CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .sel      (bus_addr[ADDR_W-1:2]),
    .cnt_all  (cnt_all),
    .load_all (load_all),
    .mode_all (mode_all),
    .en_all   (en_all),
    .mask_all (mask_all),
    .pend_all (pend_all),
    .busy_all (busy_all),
    .rdata_o  (bus_rdata)
  );

endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
  import tmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_o;

  always #2.5 clk = ~clk;

  tmr_bank u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  // Monitor: compares every expected item in the cycle it falls due
  always @(posedge clk) begin
    #1;
    cyc++;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] act;
        act = sb[i].is_irq ? {24'b0, irq_o} : bus_rdata;
        checks++;
        if (act !== sb[i].exp) begin
          fails++;
          $display("FAIL %s cycle %0d %s actual %h expected %h", sb[i].tag, cyc,
                   sb[i].is_irq ? "irq" : "rdata", act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  function automatic logic [7:0] A(input int ch, input reg_sel_e rs);
    return {ch[2:0], rs, 2'b00};
  endfunction

  task automatic push(input int due, input bit is_irq, input logic [31:0] exp, input string tag);
    item_t it;
    it.due = due; it.is_irq = is_irq; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input int ch, input reg_sel_e rs, input logic [31:0] d);
    wr_raw(A(ch, rs), d);
  endtask

  task automatic rd_seq(input int ch, input reg_sel_e rs, input logic [31:0] first,
                        input int step, input int n, input string tag);
    bus_addr = A(ch, rs);
    for (int i = 0; i < n; i++) push(cyc + 1 + i, 1'b0, first - 32'(i * step), tag);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements) actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e, d, f, s, r, m;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    push(cyc + 1, 1'b1, 32'h0, "R1");
    rd_seq(0, RS_COUNT, 0, 0, 1, "R1");
    rd_seq(0, RS_MASK, 1, 0, 1, "R1");
    rd_seq(0, RS_CLEAR, 0, 0, 1, "R1");
    rd_seq(0, RS_ENABLE, 0, 0, 1, "R1");
    rd_seq(0, RS_MODE, 0, 0, 1, "R1");

    // R2 live decrement, R3 stop and restart
    wr(0, RS_LOAD, 100);
    wr(0, RS_ENABLE, 1);
    e = cyc;
    rd_seq(0, RS_COUNT, 100, 1, 4, "R2");
    wr(0, RS_ENABLE, 0);
    d = cyc;
    rd_seq(0, RS_COUNT, 32'(100 - (d - e)), 0, 3, "R3");
    wr(0, RS_ENABLE, 1);
    f = cyc;
    rd_seq(0, RS_COUNT, 100, 1, 3, "R3");
    wr(0, RS_ENABLE, 0);
    d = cyc;

    // R4 start value write alone keeps count; reload strobe with data 0 copies it
    wr(0, RS_LOAD, 50);
    rd_seq(0, RS_COUNT, 32'(100 - (d - f)), 0, 1, "R4");
    wr(0, RS_RELOAD, 0);
    rd_seq(0, RS_COUNT, 50, 0, 2, "R4");

    // R5 continuous, R7 busy window, R9 irq on channel 1
    wr(1, RS_MODE, 1);
    wr(1, RS_LOAD, 5);
    wr(1, RS_MASK, 0);
    wr(1, RS_ENABLE, 1);
    e = cyc;
    bus_addr = A(1, RS_CLEAR);
    for (int k = 0; k < 9; k++)
      push(e + 1 + k, 1'b0, (k < 6) ? 32'd0 : (k < 8) ? 32'd3 : 32'd2, "R7");
    push(e + 5, 1'b1, 32'h00, "R5");
    push(e + 6, 1'b1, 32'h02, "R5");
    wait_until(e + 12);

    // R8 clears refused during busy after the second expiry, accepted after
    push(e + 14, 1'b1, 32'h02, "R8");
    push(e + 15, 1'b1, 32'h00, "R8");
    push(e + 17, 1'b1, 32'h00, "R5");
    push(e + 18, 1'b1, 32'h02, "R5");
    wr(1, RS_CLEAR, 1);
    wr(1, RS_CLEAR, 1);
    wr(1, RS_CLEAR, 1);
    wait_until(e + 18);
    wr(1, RS_ENABLE, 0);
    rd_seq(1, RS_COUNT, 4, 0, 1, "R5");

    // R9 mask keeps pending but silences line
    wait_until(e + 22);
    push(cyc + 1, 1'b1, 32'h00, "R9");
    wr(1, RS_MASK, 1);
    m = cyc;
    rd_seq(1, RS_CLEAR, 2, 0, 1, "R9");
    push(cyc + 1, 1'b1, 32'h02, "R9");
    wr(1, RS_MASK, 0);
    push(cyc + 1, 1'b1, 32'h00, "R8");
    wr(1, RS_CLEAR, 1);

    // R6 single-shot on channel 2
    wr(2, RS_MODE, 0);
    wr(2, RS_LOAD, 3);
    wr(2, RS_MASK, 0);
    wr(2, RS_ENABLE, 1);
    s = cyc;
    push(s + 3, 1'b1, 32'h00, "R6");
    push(s + 4, 1'b1, 32'h04, "R6");
    wait_until(s + 8);
    rd_seq(2, RS_COUNT, 0, 0, 3, "R6");
    push(cyc + 1, 1'b1, 32'h00, "R6");
    wr(2, RS_CLEAR, 1);
    push(cyc + 6, 1'b1, 32'h00, "R6");
    wait_until(cyc + 7);
    wr(2, RS_RELOAD, 1);
    r = cyc;
    push(r + 3, 1'b1, 32'h00, "R6");
    push(r + 4, 1'b1, 32'h04, "R6");
    wait_until(r + 5);

    // R10 independence and misaligned write
    wr(7, RS_LOAD, 32'hDEADBEEF);
    wr_raw(A(6, RS_LOAD) | 8'h01, 32'h1234);
    rd_seq(7, RS_LOAD, 32'hDEADBEEF, 0, 1, "R10");
    rd_seq(6, RS_LOAD, 0, 0, 1, "R10");
    rd_seq(7, RS_ENABLE, 0, 0, 1, "R10");
    rd_seq(0, RS_LOAD, 50, 0, 1, "R10");
    if (m < 0) fails++;

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails += sb.size();
      $display("FAIL scoreboard (all requirements) actual %0d unchecked expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule